// File: doc/BRIEF.md
# Underflow Interval Timer

This block is a free-running 32-bit down-counter used as a coarse interval or watchdog timer beside a network controller. Software sees the count as two 16-bit halves, one holding the upper bits and one the lower bits. Each half can be written on its own, and both halves can always be read back live. The counter moves one step on each cycle where `tick_en` is high. That strobe comes from a divider outside the block and stands for a 5 MHz timebase.

Counting is governed by three command pulses: start, stop and a software reset, which halts the timer the same way stop does. When the counter steps below zero it wraps to all ones and keeps running. The same step raises a sticky timer-complete flag. Software clears that flag with a write-one strobe, and the flag feeds an interrupt combiner outside the block.

Top module: `wdt_interval_timer`

## Requirements
- R1: After `rst_n` is released, `running` is 0, both count halves read 0 and `tc_flag` is 0.
- R2: `cnt_hi` shows count bits 31:16 and `cnt_lo` shows bits 15:0. A `wr_hi` or `wr_lo` pulse loads that half from `wr_data` at the next edge and leaves the other half unchanged. Both halves may be written in the same cycle.
- R3: While `running` is 1, each cycle with `tick_en` high lowers the 32-bit count by exactly one. This holds unless the same cycle carries a count write, `cmd_stop` or `cmd_soft_rst`.
- R4: A counting tick taken at count 0 reloads the count to 0xFFFFFFFF. In the next cycle `tc_flag` reads 1.
- R5: `cmd_stop` or `cmd_soft_rst` makes `running` 0 from the next cycle. Either one wins over a `cmd_start` in the same cycle, and no step is taken in that cycle.
- R6: `cmd_start` without a halt command makes `running` 1 from the next cycle. Counting resumes from the count held at that moment. If the timer was stopped, the count does not change in the start cycle.
- R7: While `running` is 0, `tick_en` has no effect on the count.
- R8: A count write in a cycle with a counting tick takes precedence: the written value appears, and the countdown continues from it.
- R9: `tc_flag` stays 1 until a cycle with `tc_clr` high. If an underflow occurs in that same cycle, the flag stays 1.
- R10: Count writes never change `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timebase strobe |
| wr_hi | input | 1 | Load upper count half from wr_data |
| wr_lo | input | 1 | Load lower count half from wr_data |
| wr_data | input | 16 | Write data for the count halves |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_soft_rst | input | 1 | Software reset command pulse (halts timer) |
| tc_clr | input | 1 | Write-one-to-clear strobe for the timer-complete flag |
| cnt_hi | output | 16 | Live count, upper half |
| cnt_lo | output | 16 | Live count, lower half |
| running | output | 1 | Timer running state |
| tc_flag | output | 1 | Sticky timer-complete status |

## Verification
Two pairs of functions can land on the same edge, and both are judged against the expected result. The first pair is a counting tick and a count write. The bench provokes it by writing one half while the timer runs with `tick_en` high, and expects the written value with no decrement. The second pair is an underflow and a flag clear. The bench drives `tc_clr` in the exact cycle where a tick hits count 0, and expects `tc_flag` still set together with the all-ones reload. Random stimulus with small written values makes both collisions recur, as well as start and stop arriving together.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        RUN_HOLD  = 2'd0,
        RUN_START = 2'd1,
        RUN_HALT  = 2'd2
    } run_req_e;

    function automatic run_req_e decode_run_req(input logic start,
                                                input logic stop,
                                                input logic soft_rst);
        if (stop || soft_rst) return RUN_HALT;
        if (start)            return RUN_START;
        return RUN_HOLD;
    endfunction

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic cmd_soft_rst,
    output logic run_q_o,
    output logic halt_o
);
    typedef struct packed {
        logic run;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    run_req_e    req;

    always_comb begin
        req  = decode_run_req(cmd_start, cmd_stop, cmd_soft_rst);
        st_d = st_q;
        case (req)
            RUN_HALT:  st_d.run = 1'b0;
            RUN_START: st_d.run = 1'b1;
            default:   st_d.run = st_q.run;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_q_o = st_q.run;
    assign halt_o  = (req == RUN_HALT);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NHALF-1:0]  wr_half,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              step_en,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              uf_o
);
    localparam int NHALF = CNT_W / HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t        st_d, st_q;
    logic [CNT_W-1:0]  stepped;
    logic [CNT_W-1:0]  merged;
    logic              at_zero;

    assign at_zero = (st_q.cnt == '0);
    assign stepped = at_zero ? {CNT_W{1'b1}} : (st_q.cnt - 1'b1);

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign merged[h*HALF_W +: HALF_W] =
            wr_half[h] ? wr_data
                       : (step_en ? stepped[h*HALF_W +: HALF_W]
                                  : st_q.cnt[h*HALF_W +: HALF_W]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign uf_o  = step_en && at_zero;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic tc;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tc = (st_q.tc && !clr_i) || set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.tc;
endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_soft_rst,
    input  logic              tc_clr,
    output logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic              running,
    output logic              tc_flag
);
    localparam int NHALF = CNT_W / HALF_W;

    logic              run_q;
    logic              halt;
    logic              step_en;
    logic              uf;
    logic [NHALF-1:0]  wr_half;
    logic [CNT_W-1:0]  cnt;

    assign wr_half = {wr_hi, wr_lo};
    assign step_en = run_q && tick_en && !halt && !(|wr_half);

    wdt_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_stop     (cmd_stop),
        .cmd_soft_rst (cmd_soft_rst),
        .run_q_o      (run_q),
        .halt_o       (halt)
    );

    wdt_counter #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_half (wr_half),
        .wr_data (wr_data),
        .step_en (step_en),
        .cnt_o   (cnt),
        .uf_o    (uf)
    );

    wdt_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (uf),
        .clr_i  (tc_clr),
        .flag_o (tc_flag)
    );

    assign cnt_hi  = cnt[CNT_W-1 -: HALF_W];
    assign cnt_lo  = cnt[HALF_W-1:0];
    assign running = run_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_hi,
    input logic              wr_lo,
    input logic [HALF_W-1:0] wr_data,
    input logic              cmd_start,
    input logic              cmd_stop,
    input logic              cmd_soft_rst,
    input logic              tc_clr,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cnt_lo,
    input logic              running,
    input logic              tc_flag
);
    logic [2*HALF_W-1:0] full;
    logic                quiet;
    assign full  = {cnt_hi, cnt_lo};
    assign quiet = !wr_hi && !wr_lo && !cmd_stop && !cmd_soft_rst;

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        running && tick_en && quiet && (full != '0) |=> full == $past(full) - 1'b1);

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        running && tick_en && quiet && (full == '0) |=> (&full) && tc_flag);

    a_r5_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop || cmd_soft_rst) |=> !running);

    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && !cmd_stop && !cmd_soft_rst |=> running);

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !wr_hi && !wr_lo |=> $stable(full));

    a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_lo == $past(wr_data));

    a_r8_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cnt_hi == $past(wr_data));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tc_flag && !tc_clr |=> tc_flag);

    a_r10_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_start && !cmd_stop && !cmd_soft_rst |=> running == $past(running));
endmodule

bind wdt_interval_timer wdt_checker #(.HALF_W(HALF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .wr_hi        (wr_hi),
    .wr_lo        (wr_lo),
    .wr_data      (wr_data),
    .cmd_start    (cmd_start),
    .cmd_stop     (cmd_stop),
    .cmd_soft_rst (cmd_soft_rst),
    .tc_clr       (tc_clr),
    .cnt_hi       (cnt_hi),
    .cnt_lo       (cnt_lo),
    .running      (running),
    .tc_flag      (tc_flag)
);

// File: tb/sim_wdt_interval_timer.sv
module sim_wdt_interval_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 0, wr_hi = 0, wr_lo = 0;
    logic [15:0] wr_data = '0;
    logic        cmd_start = 0, cmd_stop = 0, cmd_soft_rst = 0, tc_clr = 0;
    logic [15:0] cnt_hi, cnt_lo;
    logic        running, tc_flag;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [31:0] m_cnt;
    logic        m_run;
    logic        m_tc;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_soft_rst(cmd_soft_rst), .tc_clr(tc_clr), .cnt_hi(cnt_hi),
        .cnt_lo(cnt_lo), .running(running), .tc_flag(tc_flag)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Expected next state from the requirements R2..R10.
    function automatic logic [33:0] predict(input logic [31:0] c, input logic r,
                                            input logic t);
        logic        halt, wr, step, uf;
        logic [31:0] nc;
        logic        nr, nt;
        halt = cmd_stop || cmd_soft_rst;
        wr   = wr_hi || wr_lo;
        step = r && tick_en && !halt && !wr;
        uf   = step && (c == 32'd0);
        nc   = step ? c - 32'd1 : c;
        if (wr_hi) nc[31:16] = wr_data;
        if (wr_lo) nc[15:0]  = wr_data;
        nr = halt ? 1'b0 : (cmd_start ? 1'b1 : r);
        nt = (t && !tc_clr) || uf;
        return {nc, nr, nt};
    endfunction

    task automatic check(input string tag);
        vectors++;
        if ({cnt_hi, cnt_lo} !== m_cnt || running !== m_run || tc_flag !== m_tc) begin
            errors++;
            $display("FAIL %s: actual cnt=%h run=%b tc=%b expected cnt=%h run=%b tc=%b",
                     tag, {cnt_hi, cnt_lo}, running, tc_flag, m_cnt, m_run, m_tc);
        end
    endtask

    task automatic step(input logic tk, input logic wh, input logic wl,
                        input logic [15:0] d, input logic st, input logic sp,
                        input logic sr, input logic cl, input string tag);
        logic [33:0] p;
        @(negedge clk);
        tick_en = tk; wr_hi = wh; wr_lo = wl; wr_data = d;
        cmd_start = st; cmd_stop = sp; cmd_soft_rst = sr; tc_clr = cl;
        p = predict(m_cnt, m_run, m_tc);
        @(posedge clk);
        #1;
        {m_cnt, m_run, m_tc} = p;
        check(tag);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        m_cnt = '0; m_run = 0; m_tc = 0;
        #1 check("R1 reset state");

        // R7: ticks while stopped leave count alone
        step(1,0,0,16'h0,0,0,0,0, "R7 tick while stopped");
        // R2: separate and joint half writes, R10: no start
        step(0,1,0,16'hA5A5,0,0,0,0, "R2 write upper half");
        step(0,0,1,16'h0003,0,0,0,0, "R2 write lower half");
        step(1,1,1,16'h0000,0,0,0,0, "R2 R10 write both halves");
        step(0,0,1,16'h0002,0,0,0,0, "R2 lower only");
        // R6: start, no step in the start cycle even with tick
        step(1,0,0,16'h0,1,0,0,0, "R6 start cycle");
        step(1,0,0,16'h0,0,0,0,0, "R3 first tick");
        step(0,0,0,16'h0,0,0,0,0, "R3 idle no tick");
        step(1,0,0,16'h0,0,0,0,0, "R3 to zero");
        // R4 with simultaneous clear: R9
        step(1,0,0,16'h0,0,0,0,1, "R4 R9 underflow during clear");
        step(0,0,0,16'h0,0,0,0,0, "R9 flag held");
        step(1,0,0,16'h0,0,0,0,1, "R9 clear");
        // R8: write beats tick
        step(1,0,1,16'h0010,0,0,0,0, "R8 write with tick");
        step(1,0,0,16'h0,0,0,0,0, "R8 count continues");
        // R5: stop wins over start, no step
        step(1,0,0,16'h0,1,1,0,0, "R5 stop wins");
        step(1,0,0,16'h0,0,0,0,0, "R7 frozen after stop");
        step(0,0,0,16'h0,1,0,0,0, "R6 restart");
        step(1,0,0,16'h0,1,0,1,0, "R5 soft reset halts");
        step(1,1,0,16'h0001,0,0,0,0, "R10 write keeps stopped");
        // lower-half borrow into upper half
        step(0,0,1,16'h0000,1,0,0,0, "R2 setup borrow");
        step(1,0,0,16'h0,0,0,0,0, "R3 borrow across halves");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2] & r[3] & r[4], r[5] & r[6] & r[7],
                 {14'd0, r[9:8]}, r[10] & r[11], r[12] & r[13] & r[14],
                 r[15] & r[16] & r[17] & r[18], r[19] & r[20],
                 "R3 R4 R5 R6 R8 R9 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule